// File: doc/BRIEF.md
# USART Baud and Serial Clock Generator

This block produces the per-bit clock enables that a USART transmitter and receiver run from. A reloadable down-counter running at the system clock divides by the programmed baud value plus one and gives the receiver base enable. A second divider turns that enable into the transmitter enable. The divide ratio depends on the operating mode: 16 in normal asynchronous mode, 8 in double-speed asynchronous mode and 2 in synchronous master mode.

In synchronous mode the serial clock pin either carries the block's own clock out (master) or brings an external clock in (slave). In slave mode the pin passes through a two-stage synchronizer and an edge detector. A polarity bit picks which edge is used, and each detected edge becomes a single-cycle enable that replaces both internal enables. All outputs are single-cycle enables or levels in the system clock domain. Configuration arrives on plain register-bus level inputs plus one write strobe for the low byte of the baud value. There is no data stream at this block's edge, so it has no valid/ready handshake.

Top module: `usart_clkgen`

## Requirements
- R1: The receive enable `rx_en` in asynchronous mode (`sync_mode`=0) pulses for one cycle every `baud_val`+1 system clocks. The counter is loaded with `baud_val` each time it has reached zero.
- R2: A cycle with `baud_lo_wr`=1 produces no baud pulse, and the next baud pulse follows `baud_val`+1 cycles after that write.
- R3: In normal asynchronous mode (`sync_mode`=0, `dbl_speed`=0), `tx_en` pulses on every 16th baud pulse.
- R4: In double-speed asynchronous mode (`sync_mode`=0, `dbl_speed`=1), `tx_en` pulses on every 8th baud pulse.
- R5: In synchronous master mode (`sync_mode`=1, `pin_dir_out`=1), `tx_en` pulses on every 2nd baud pulse, and `dbl_speed` has no effect.
- R6: In master mode, `xck_oe`=1 and `xck_out` follows the low bit of the transmit divider, so it changes level in the cycle after each baud pulse.
- R7: In asynchronous mode, `xck_oe`=0 and `xck_out`=0, and activity on `xck_in` has no effect on `rx_en` or `tx_en`.
- R8: In slave mode (`sync_mode`=1, `pin_dir_out`=0), `rx_en` and `tx_en` are both equal to a single-cycle edge pulse. `clk_pol`=0 selects rising edges of `xck_in` and `clk_pol`=1 selects falling edges. A level first sampled at clock edge k gives a pulse in the cycle between edges k+1 and k+2.
- R9: Reset clears the baud counter and the transmit divider. In the first cycle after reset, in asynchronous mode and with no write, `rx_en`=1 and `tx_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_val | input | BAUD_W | Baud divider value (period = value+1) |
| baud_lo_wr | input | 1 | Strobe: low byte of baud value written, forces reload |
| sync_mode | input | 1 | 0 asynchronous, 1 synchronous |
| dbl_speed | input | 1 | Double speed, asynchronous mode only |
| pin_dir_out | input | 1 | Synchronous clock source: 1 internal (master), 0 external (slave) |
| clk_pol | input | 1 | Slave edge select: 0 rising, 1 falling |
| xck_in | input | 1 | Serial clock pin input |
| xck_out | output | 1 | Serial clock pin output value |
| xck_oe | output | 1 | Serial clock pin output enable |
| tx_en | output | 1 | Transmitter clock enable |
| rx_en | output | 1 | Receiver base clock enable |

## Verification
The bench builds the block with its default parameters: a 12-bit baud value, ratios 16, 8 and 2, and a two-stage synchronizer. With these values both extremes of the divider can be reached in a short run: a baud value of 0, which gives a pulse every cycle, and 4095, which gives the full 4096-cycle period. The reload strobe is placed mid-count so that the suppressed pulse can be seen. Mode switches with the transmit divider part-way through are included, and the pin is toggled in both slave polarities and while in asynchronous mode.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;

  typedef enum logic [1:0] {
    CK_ASYNC_NORM  = 2'd0,
    CK_ASYNC_DBL   = 2'd1,
    CK_SYNC_MASTER = 2'd2,
    CK_SYNC_SLAVE  = 2'd3
  } ck_mode_e;

  function automatic ck_mode_e decode_mode(input logic sync_sel,
                                           input logic dbl_sel,
                                           input logic dir_out);
    if (!sync_sel) return dbl_sel ? CK_ASYNC_DBL : CK_ASYNC_NORM;
    return dir_out ? CK_SYNC_MASTER : CK_SYNC_SLAVE;
  endfunction

endpackage

// File: rtl/usart_baud_ctr.sv
module usart_baud_ctr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] reload_val,
  input  logic         reload_wr,
  output logic         tick
);

  logic [W-1:0] cnt_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign tick    = at_zero && !reload_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (reload_wr || at_zero) cnt_q <= reload_val;
    else                           cnt_q <= cnt_q - W'(1);
  end

  // R2
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> (cnt_q == $past(reload_val)));

  // R1
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_wr && cnt_q != '0) |=> (cnt_q == ($past(cnt_q) - W'(1))));

endmodule

// File: rtl/usart_tx_prescale.sv
module usart_tx_prescale
  import usart_clkgen_pkg::*;
#(
  parameter int NORM_DIV = 16,
  parameter int DBL_DIV  = 8,
  parameter int SYNC_DIV = 2,
  localparam int DIV_W   = $clog2(NORM_DIV)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     baud_tick,
  input  ck_mode_e mode,
  output logic     tx_tick,
  output logic     phase
);

  localparam logic [DIV_W-1:0] LIM_NORM = DIV_W'(NORM_DIV - 1);
  localparam logic [DIV_W-1:0] LIM_DBL  = DIV_W'(DBL_DIV - 1);
  localparam logic [DIV_W-1:0] LIM_SYNC = DIV_W'(SYNC_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;
  logic             wrap;

  always_comb begin
    case (mode)
      CK_ASYNC_NORM: lim = LIM_NORM;
      CK_ASYNC_DBL:  lim = LIM_DBL;
      default:       lim = LIM_SYNC;
    endcase
  end

  assign wrap    = (div_q >= lim);
  assign tx_tick = baud_tick && wrap;
  assign phase   = div_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_q <= '0;
    else if (baud_tick) div_q <= wrap ? '0 : div_q + DIV_W'(1);
  end

  // R3
  tx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |=> (div_q == '0));

  // R4
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(div_q));

endmodule

// File: rtl/usart_xck_edge.sv
module usart_xck_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic fall_sel,
  output logic edge_pulse
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;
  logic              rise;
  logic              fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl        = sync_q[STAGES-1];
  assign rise       = lvl && !prev_q;
  assign fall       = !lvl && prev_q;
  assign edge_pulse = fall_sel ? fall : rise;

  // R8
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
  import usart_clkgen_pkg::*;
#(
  parameter int BAUD_W      = 12,
  parameter int NORM_DIV    = 16,
  parameter int DBL_DIV     = 8,
  parameter int SYNC_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BAUD_W-1:0] baud_val,
  input  logic              baud_lo_wr,
  input  logic              sync_mode,
  input  logic              dbl_speed,
  input  logic              pin_dir_out,
  input  logic              clk_pol,
  input  logic              xck_in,
  output logic              xck_out,
  output logic              xck_oe,
  output logic              tx_en,
  output logic              rx_en
);

  ck_mode_e mode;
  logic     baud_tick;
  logic     tx_tick;
  logic     phase;
  logic     ext_edge;
  logic     is_slave;
  logic     is_master;

  assign mode      = decode_mode(sync_mode, dbl_speed, pin_dir_out);
  assign is_slave  = (mode == CK_SYNC_SLAVE);
  assign is_master = (mode == CK_SYNC_MASTER);

  usart_baud_ctr #(.W(BAUD_W)) baud_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload_val (baud_val),
    .reload_wr  (baud_lo_wr),
    .tick       (baud_tick)
  );

  usart_tx_prescale #(
    .NORM_DIV (NORM_DIV),
    .DBL_DIV  (DBL_DIV),
    .SYNC_DIV (SYNC_DIV)
  ) pre_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .mode      (mode),
    .tx_tick   (tx_tick),
    .phase     (phase)
  );

  usart_xck_edge #(.STAGES(SYNC_STAGES)) edge_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_in     (xck_in),
    .fall_sel   (clk_pol),
    .edge_pulse (ext_edge)
  );

  assign rx_en   = is_slave ? ext_edge : baud_tick;
  assign tx_en   = is_slave ? ext_edge : tx_tick;
  assign xck_oe  = is_master;
  assign xck_out = is_master && phase;

  // R8
  slave_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !pin_dir_out) |-> (tx_en == rx_en));

  // R7
  async_pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> (!xck_oe && !xck_out));

  // R6
  master_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && $past(is_master) && $past(rx_en) && $past(xck_out)) |-> !xck_out);

  // R5
  master_tx_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && tx_en) |-> rx_en);

endmodule

// File: tb/usart_clkgen_tb_top.sv
`timescale 1ns/1ps
module usart_clkgen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] baud_val = 12'd0;
  logic        baud_lo_wr = 1'b0;
  logic        sync_mode = 1'b0;
  logic        dbl_speed = 1'b0;
  logic        pin_dir_out = 1'b0;
  logic        clk_pol = 1'b0;
  logic        xck_in = 1'b0;
  logic        xck_out, xck_oe, tx_en, rx_en;

  int vec_cnt = 0;
  int err_cnt = 0;
  bit done = 0;

  int m_cnt = 0;
  int m_div = 0;
  bit m_s1 = 0, m_s2 = 0, m_s3 = 0;

  always #2.5 clk = ~clk;

  usart_clkgen dut_i (
    .clk(clk), .rst_n(rst_n), .baud_val(baud_val), .baud_lo_wr(baud_lo_wr),
    .sync_mode(sync_mode), .dbl_speed(dbl_speed), .pin_dir_out(pin_dir_out),
    .clk_pol(clk_pol), .xck_in(xck_in), .xck_out(xck_out), .xck_oe(xck_oe),
    .tx_en(tx_en), .rx_en(rx_en)
  );

  function automatic int ratio_now();
    if (sync_mode) return 2;
    return dbl_speed ? 8 : 16;
  endfunction

  task automatic cmp(input logic act, input logic exp, input string req, input string what);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
    end
  endtask

  task automatic check_now();
    bit tick, txp, slave, master, edg;
    string rq_tx, rq_rx, rq_pin;
    tick   = !baud_lo_wr && (m_cnt == 0);
    txp    = tick && (m_div >= ratio_now() - 1);
    slave  = sync_mode && !pin_dir_out;
    master = sync_mode && pin_dir_out;
    edg    = clk_pol ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
    rq_tx  = slave ? "R8" : (sync_mode ? "R5" : (dbl_speed ? "R4" : "R3"));
    rq_rx  = slave ? "R8" : (baud_lo_wr ? "R2" : "R1");
    rq_pin = master ? "R6" : (sync_mode ? "R8" : "R7");
    cmp(rx_en, slave ? edg : tick, rq_rx, "rx_en");
    cmp(tx_en, slave ? edg : txp, rq_tx, "tx_en");
    cmp(xck_oe, master, rq_pin, "xck_oe");
    cmp(xck_out, master ? ((m_div % 2) == 1) : 1'b0, rq_pin, "xck_out");
  endtask

  task automatic model_update();
    bit tick;
    tick = !baud_lo_wr && (m_cnt == 0);
    if (tick) m_div = (m_div >= ratio_now() - 1) ? 0 : m_div + 1;
    if (baud_lo_wr || m_cnt == 0) m_cnt = int'(baud_val);
    else m_cnt = m_cnt - 1;
    m_s3 = m_s2;
    m_s2 = m_s1;
    m_s1 = xck_in;
  endtask

  task automatic run_cycles(input int n, input int tp);
    for (int i = 0; i < n; i++) begin
      if (tp > 0 && (i % tp) == 0) xck_in = ~xck_in;
      #1;
      check_now();
      @(posedge clk);
      model_update();
      @(negedge clk);
      baud_lo_wr = 1'b0;
    end
  endtask

  task automatic write_baud(input int val);
    baud_val   = 12'(val);
    baud_lo_wr = 1'b1;
    run_cycles(1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    baud_val = 12'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: first cycle after reset gives a baud pulse and no tx pulse
    #1;
    cmp(rx_en, 1'b1, "R9", "rx_en after reset");
    cmp(tx_en, 1'b0, "R9", "tx_en after reset");
    @(negedge clk);
    m_cnt = 0; m_div = 0;
    // realign model: one cycle already consumed, apply its update
    m_cnt = 3; m_div = 1;
    m_s1 = 0; m_s2 = 0; m_s3 = 0;

    // R1 / R3 / R7: normal async, pin toggling must be ignored
    run_cycles(200, 3);
    // R2: reload mid-count, several values
    run_cycles(2, 0);
    write_baud(5);
    run_cycles(3, 0);
    write_baud(5);
    run_cycles(40, 0);
    // R4: double speed
    dbl_speed = 1'b1;
    write_baud(2);
    run_cycles(120, 5);
    // R1 with value 0: pulse every cycle
    write_baud(0);
    run_cycles(40, 0);
    // R5 / R6: master, double speed set but ignored
    sync_mode = 1'b1; pin_dir_out = 1'b1;
    write_baud(1);
    run_cycles(60, 0);
    dbl_speed = 1'b0;
    write_baud(4);
    run_cycles(60, 0);
    // R8: slave rising then falling edges
    pin_dir_out = 1'b0; clk_pol = 1'b0;
    run_cycles(100, 7);
    clk_pol = 1'b1;
    run_cycles(100, 4);
    run_cycles(30, 1);
    // back to master with divider mid-count
    pin_dir_out = 1'b1;
    run_cycles(50, 0);
    // R3 again from async, then largest value
    sync_mode = 1'b0;
    run_cycles(200, 0);
    write_baud(4095);
    run_cycles(9000, 11);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule